// File: doc/BRIEF.md
# Video Double-Buffer Pointer Controller

This block selects the halves of a two-half frame buffer so that streamed video appears in a window of an LCD image without tearing. The upper half holds the static image and also serves as one of the two video buffers. The lower half is the other video buffer. While the host writes one video frame into one half, the display reads the video window from the other half, which holds the most recent complete frame. Static (non-video) data is always written to, and displayed from, the upper half.

The host reports each video burst with a frame-start strobe and a frame-done strobe. The display timing reports the start of vertical blanking with a single-cycle strobe. The write and read halves trade places at most once per display frame, and only at that strobe. The trade happens only if a video frame finished since the last trade and no new burst is in progress at that moment. Otherwise both halves stay as they are. If a frame is written too soon, it overwrites the pending one, and the pending frame is never shown.

A 2-bit mode input turns the scheme on only when it reads 11b. Any other value sends every write and read to the upper half and returns the internal state to its reset values.

Top module: `vid_dbuf_ctrl`

## Requirements
- R1: A write with `video_wr` = 0 (static data) always reports `wr_half` = 0, the upper half, in every mode.
- R2: After reset, or after the mode becomes 11b, the first video write (`video_wr` = 1) reports `wr_half` = 1, the lower half. After the first trade, video writes report `wr_half` = 0.
- R3: While `mode` is not 11b, `wr_half` and `vid_rd_half` are both 0.
- R4: `vid_rd_half` and the video write half change only on the clock edge that samples `vblank_start` = 1, and they take effect from the next cycle.
- R5: At a `vblank_start` edge, the halves trade if and only if a frame completed since the last trade (or `frame_done` is high in that same cycle) and no burst is in progress.
- R6: A `frame_done` that arrives in the same cycle as `vblank_start` counts as completed for that trade, as long as `frame_start` is low.
- R7: A `frame_start` in the same cycle as `vblank_start` blocks the trade, and so does a burst that started earlier and has not yet ended.
- R8: Two or more frames that complete between vertical-blank strobes cause exactly one trade. The second frame overwrites the same half.
- R9: Reset (`rst_n` = 0 at a clock edge), or a mode other than 11b, sets the video write half to 1 and the video read half to 0, and clears the pending-completion state. A stale completion therefore causes no trade after the mode is set to 11b again.
- R10: While the mode is 11b, the video read half and the video write half always differ.
- R11: A `vblank_start` with no completed frame pending leaves both halves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Double-buffer control field; 11b enables the scheme |
| video_wr | input | 1 | 1 when the current host write carries video data, 0 for static data |
| frame_start | input | 1 | One-cycle strobe at the start of a video frame burst |
| frame_done | input | 1 | One-cycle strobe at the end of a video frame burst |
| vblank_start | input | 1 | One-cycle strobe at the start of the vertical non-display period |
| wr_half | output | 1 | Half for the current write (0 upper, 1 lower) |
| vid_rd_half | output | 1 | Half the display reads the video window from (0 upper, 1 lower) |

## Verification
The bench starts from each of the four combinations of the pending-completion and in-progress states. From each one it applies every combination of `frame_start`, `frame_done` and `vblank_start` together, so it covers the same-cycle corner cases of R6 and R7. A design that ignores a same-cycle `frame_done` skips a display frame. A design that lets a same-cycle `frame_start` through shows a half that is still being written, which tears the image. Back-to-back completions probe R8: a design that toggles once per completion ends up on the wrong half. A stale completion left over across a mode change probes R9: a design that does not clear it trades at the first blanking strobe with no new frame. A long pseudo-random run then compares both outputs against a model in the bench on every cycle.

// File: rtl/dbuf_pkg.sv
// Package: shared encodings for the video double-buffer controller.
// Assumes a two-half buffer; the upper half also holds the static image.
package dbuf_pkg;
    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_ON = 2'b11;

    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_t;

    // Return the other half of the buffer.
    function automatic half_t other_half(input half_t h);
        return (h == HALF_UPPER) ? HALF_LOWER : HALF_UPPER;
    endfunction
endpackage

// File: rtl/dbuf_status.sv
// Module: tracks the burst-in-progress and frame-completed flags and decides
// whether a trade of halves is allowed at this vertical-blank strobe.
// Assumes single-cycle strobes; an enable of 0 acts as a synchronous clear.
module dbuf_status (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic frame_start,
    input  logic frame_done,
    input  logic vblank_start,
    output logic swap
);
    logic busy_q;
    logic done_q;
    logic blocked;
    logic have_frame;

    // A burst blocks the trade if it starts now or is still open.
    assign blocked    = frame_start | (busy_q & ~frame_done);
    // A frame that ends in this same cycle already counts.
    assign have_frame = done_q | frame_done;
    assign swap       = en & vblank_start & have_frame & ~blocked;

    // Burst-in-progress flag: set by frame start, cleared by frame done.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)      busy_q <= 1'b0;
        else if (frame_start)   busy_q <= 1'b1;
        else if (frame_done)    busy_q <= 1'b0;
    end

    // Sticky completion flag: set by frame done, consumed by a trade.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)      done_q <= 1'b0;
        else if (swap)          done_q <= 1'b0;
        else if (frame_done)    done_q <= 1'b1;
    end

    // R7
    start_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !swap);

    // R9
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!done_q && !busy_q));

    // R8
    done_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> !done_q);
endmodule

// File: rtl/dbuf_pointers.sv
// Module: holds the video write half and the video read half and trades
// them when told to. Assumes swap is asserted only while enabled.
module dbuf_pointers
    import dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  swap,
    output half_t wr_ptr,
    output half_t rd_ptr
);
    // Pointer registers: reset or disable restores lower-write / upper-read.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            wr_ptr <= HALF_LOWER;
            rd_ptr <= HALF_UPPER;
        end else if (swap) begin
            wr_ptr <= other_half(wr_ptr);
            rd_ptr <= other_half(rd_ptr);
        end
    end

    // R10
    halves_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr != rd_ptr);

    // R9
    disable_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (wr_ptr == HALF_LOWER && rd_ptr == HALF_UPPER));
endmodule

// File: rtl/vid_dbuf_ctrl.sv
// Module: top of the video double-buffer controller. It routes static
// writes to the upper half and video traffic to the tracked halves.
// Assumes all strobes are synchronous to clk and one cycle wide.
module vid_dbuf_ctrl
    import dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              video_wr,
    input  logic              frame_start,
    input  logic              frame_done,
    input  logic              vblank_start,
    output logic              wr_half,
    output logic              vid_rd_half
);
    logic  en;
    logic  swap;
    half_t wr_ptr;
    half_t rd_ptr;

    assign en = (mode == MODE_ON);

    dbuf_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .frame_start  (frame_start),
        .frame_done   (frame_done),
        .vblank_start (vblank_start),
        .swap         (swap)
    );

    dbuf_pointers u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .swap   (swap),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr)
    );

    // Output select: static data and disabled mode always use the upper half.
    always_comb begin
        wr_half     = (en && video_wr) ? wr_ptr : HALF_UPPER;
        vid_rd_half = en ? rd_ptr : HALF_UPPER;
    end

    // R4
    swap_at_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$stable(rd_ptr)) |-> $past(vblank_start));

    // R11
    idle_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !vblank_start) |=> $stable(rd_ptr));

    // R1
    static_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !video_wr |-> (wr_half == HALF_UPPER));
endmodule

// File: tb/test_vid_dbuf_ctrl.sv
module test_vid_dbuf_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       video_wr = 1'b0;
    logic       frame_start = 1'b0;
    logic       frame_done = 1'b0;
    logic       vblank_start = 1'b0;
    logic       wr_half;
    logic       vid_rd_half;

    int n_chk = 0;
    int n_fail = 0;
    // bench model: video write half, video read half, pending, in-progress
    logic m_wr = 1'b1, m_rd = 1'b0, m_pend = 1'b0, m_open = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_dbuf_ctrl i_vid_dbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .video_wr(video_wr),
        .frame_start(frame_start), .frame_done(frame_done),
        .vblank_start(vblank_start), .wr_half(wr_half), .vid_rd_half(vid_rd_half)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b expected=%b t=%0t", tag, got, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check outputs, advance the model at posedge.
    task automatic step(input logic [1:0] md, input logic vw, input logic fs,
                        input logic fd, input logic vb, input string tag);
        logic on, stop, trade;
        @(negedge clk);
        mode = md; video_wr = vw; frame_start = fs; frame_done = fd; vblank_start = vb;
        #1;
        on = (md == 2'b11);
        check(vw ? (on ? "R2" : "R3") : "R1", wr_half, (on && vw) ? m_wr : 1'b0);
        check(on ? tag : "R3", vid_rd_half, on ? m_rd : 1'b0);
        stop  = fs || (m_open && !fd);
        trade = on && vb && (m_pend || fd) && !stop;
        @(posedge clk);
        if (!rst_n || !on) begin
            m_wr = 1'b1; m_rd = 1'b0; m_pend = 1'b0; m_open = 1'b0;
        end else begin
            if (trade) begin m_wr = !m_wr; m_rd = !m_rd; end
            m_pend = trade ? 1'b0 : (fd ? 1'b1 : m_pend);
            m_open = fs ? 1'b1 : (fd ? 1'b0 : m_open);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog (all requirements) got=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9 reset state, R2 first frame goes to lower half
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        check("R2", wr_half, 1'b1);
        // R11 blanking with nothing pending
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        check("R11", vid_rd_half, 1'b0);
        // R6 done and blanking together trade
        step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        step(2'b11, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        check("R6", vid_rd_half, 1'b1);
        check("R2", wr_half, 1'b0);
        check("R10", wr_half != vid_rd_half, 1'b1);
        // R8 two completions then one blanking: one trade only
        step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
        step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        check("R8", vid_rd_half, 1'b0);
        // R7 pending frame but a burst is open
        step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        check("R7", vid_rd_half, 1'b0);
        // R9 stale completion discarded by disable
        step(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        check("R9", vid_rd_half, 1'b0);
        check("R9", wr_half, 1'b1);
        // R5 R6 R7: every start state crossed with every strobe combination
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 16; c++) begin
                step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
                if (s[0]) begin
                    step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
                    step(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
                end
                if (s[1]) step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
                step(2'b11, c[3], c[0], c[1], c[2], "R5");
                step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
            end
        end
        // R4 R5 R3 R1 pseudo-random run against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((lfsr[15:13] == 3'd0) ? lfsr[1:0] : 2'b11, lfsr[9],
                 lfsr[3] & lfsr[4], lfsr[5] & lfsr[6], lfsr[7] & lfsr[8], "R4");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule